// File: doc/BRIEF.md
# Cache-Miss Load Value Predictor

This block supplies a guessed load value when a load misses in the data cache, so the pipeline can continue without waiting for the line fill. Software first writes a short list of load instruction addresses (PCs) into a small tagged table. When a miss lookup presents a PC, the block checks the table in the same cycle. It then either returns a predicted value or reports that no prediction is made. When the true data returns later, an update port trains the matching entry in the background. Wrong guesses are never repaired. Tolerating them is left to the software that chose the targets.

A two-bit mode input selects one of three prediction schemes. Last-value mode repeats the newest observed value. Stride mode adds the difference between the two newest values. Confidence-gated stride mode issues a stride guess only when a per-entry saturating counter (0 to 7) has reached a programmable threshold. Three counters report how often a prediction was issued, how often training found the entry's guess correct, and how often a gated lookup was skipped.

Top module: `miss_value_predictor`

## Requirements
- R1: A prediction (`pred_valid` high) is issued only in a cycle where `lk_miss` is high. Mode code 2'b11 disables prediction entirely. Lookups without `lk_miss` change no counter.
- R2: A lookup whose PC equals no configured entry returns no prediction. A configuration write (`cfg_we`) stores `cfg_pc` into entry `cfg_idx` and empties that entry's history and confidence.
- R3: Mode 2'b00 (last value) predicts the newest trained value, once the entry has at least one observation.
- R4: Mode 2'b01 (stride) predicts `2*newest - previous`, modulo 2^DATA_W, once the entry has at least two observations.
- R5: On each update to an entry holding at least two observations, its confidence rises by one if the update value equals the entry's stride guess, and falls by one otherwise, saturating at 0 and 7. With fewer observations, confidence is unchanged.
- R6: Mode 2'b10 (adaptive) issues the stride guess only when the entry has two or more observations and confidence is at least the threshold. The threshold resets to 4 and is rewritten by `thr_we`/`thr_val`.
- R7: An update matching an entry shifts the newest value into the previous slot and stores the new value as newest. Training happens in every mode. An update to an unconfigured PC changes nothing. A lookup in the same cycle as an update sees the state from before the update.
- R8: `cfg_clear` removes every entry, so the following lookups return no prediction.
- R9: `cnt_issued` increments once for every cycle in which a prediction is issued.
- R10: `cnt_correct` increments on each update whose entry, under the current mode and threshold and before training, would issue a guess equal to the returned value.
- R11: `cnt_skipped` increments on each miss lookup in adaptive mode that matches an entry but issues no prediction.
- R12: When several entries hold the same PC, the lowest-indexed one alone serves lookups and receives updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Scheme: 0 last value, 1 stride, 2 adaptive, 3 off |
| cfg_we | input | 1 | Write a target PC into one entry |
| cfg_idx | input | IDX_W | Entry index for the configuration write |
| cfg_pc | input | PC_W | Target load PC to store |
| cfg_clear | input | 1 | Invalidate all entries |
| thr_we | input | 1 | Write the adaptive threshold |
| thr_val | input | 3 | New threshold value |
| lk_miss | input | 1 | Load missed; request a prediction |
| lk_pc | input | PC_W | PC of the missing load |
| pred_valid | output | 1 | A prediction is issued this cycle |
| pred_value | output | DATA_W | Predicted data, meaningful when `pred_valid` is high |
| upd_valid | input | 1 | True data has returned for a load |
| upd_pc | input | PC_W | PC of the returning load |
| upd_value | input | DATA_W | Returned data |
| cnt_issued | output | CNT_W | Predictions issued |
| cnt_correct | output | CNT_W | Updates that confirmed the entry's guess |
| cnt_skipped | output | CNT_W | Adaptive lookups skipped |

## Verification
The bench targets confidence saturation at both ends. A counter that wraps above 7 or below 0 would wrongly issue a guess after a single mistake, or after a single correct outcome, under a high threshold. Stride arithmetic is driven across the 2^32 wrap and to a negative stride, so any sign or width error would show up in the guessed value. The bench also tests a lookup and an update to the same PC in one cycle: a design that forwarded the new value would predict too early. It also tests duplicate PCs in the table: a design without a fixed priority would train or read the wrong entry. A behavioural model checks the outputs and all three counters every cycle, including during a long randomised phase that changes modes and threshold.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

    localparam int CONF_W = 3;
    localparam int OBS_W  = 2;
    localparam logic [CONF_W-1:0] CONF_MAX  = 3'd7;
    localparam logic [CONF_W-1:0] THR_RESET = 3'd4;

    typedef enum logic [1:0] {
        MODE_LAST   = 2'd0,
        MODE_STRIDE = 2'd1,
        MODE_ADAPT  = 2'd2,
        MODE_OFF    = 2'd3
    } pmode_e;

    typedef struct packed {
        logic              live;
        logic [OBS_W-1:0]  nobs;
        logic [CONF_W-1:0] conf;
    } meta_t;

    function automatic logic [CONF_W-1:0] conf_step(input logic [CONF_W-1:0] c, input logic up);
        if (up) return (c == CONF_MAX) ? c : c + 1'b1;
        return (c == '0) ? c : c - 1'b1;
    endfunction

    function automatic logic [OBS_W-1:0] obs_step(input logic [OBS_W-1:0] n);
        return (n == '1) ? n : n + 1'b1;
    endfunction

endpackage

// File: rtl/lvp_entry.sv
module lvp_entry
    import lvp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cfg_sel,
    input  logic [PC_W-1:0]   cfg_pc,
    input  logic              upd_sel,
    input  logic [DATA_W-1:0] upd_value,
    output meta_t             meta,
    output logic [PC_W-1:0]   tag,
    output logic [DATA_W-1:0] h1,
    output logic [DATA_W-1:0] h2
);

    logic [DATA_W-1:0] stride_guess;
    logic              two_obs;

    assign stride_guess = h1 + (h1 - h2);
    assign two_obs      = (meta.nobs >= OBS_W'(2));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            meta <= '0;
            tag  <= '0;
            h1   <= '0;
            h2   <= '0;
        end else if (cfg_sel) begin
            meta.live <= 1'b1;
            meta.nobs <= '0;
            meta.conf <= '0;
            tag       <= cfg_pc;
            h1        <= '0;
            h2        <= '0;
        end else if (upd_sel) begin
            h2        <= h1;
            h1        <= upd_value;
            meta.nobs <= obs_step(meta.nobs);
            if (two_obs)
                meta.conf <= conf_step(meta.conf, upd_value == stride_guess);
        end
    end

    // Saturation: the counter never wraps across its range ends (R5)
    assert_conf_top_R5: assert property (@(posedge clk) disable iff (rst)
        (meta.conf == CONF_MAX && !clear && !cfg_sel) |=> (meta.conf != '0));

    assert_conf_bottom_R5: assert property (@(posedge clk) disable iff (rst)
        (meta.conf == '0 && !clear && !cfg_sel) |=> (meta.conf != CONF_MAX));

    // Confidence frozen until two observations exist (R5)
    assert_conf_needs_history_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_sel && !clear && !cfg_sel && meta.nobs < OBS_W'(2)) |=> $stable(meta.conf));

endmodule

// File: rtl/lvp_match.sv
module lvp_match #(
    parameter int N    = 8,
    parameter int PC_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     live,
    input  logic [PC_W-1:0]  tags [N],
    input  logic [PC_W-1:0]  key,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest matching index wins (R12)
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i] && tags[i] == key) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lvp_predict.sv
module lvp_predict
    import lvp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        mode,
    input  logic              sel,
    input  logic [OBS_W-1:0]  nobs,
    input  logic [CONF_W-1:0] conf,
    input  logic [CONF_W-1:0] thr,
    input  logic [DATA_W-1:0] h1,
    input  logic [DATA_W-1:0] h2,
    output logic              issue,
    output logic [DATA_W-1:0] value
);

    pmode_e            pm;
    logic              two_obs;
    logic [DATA_W-1:0] stride_guess;

    assign pm           = pmode_e'(mode);
    assign two_obs      = (nobs >= OBS_W'(2));
    assign stride_guess = h1 + (h1 - h2);

    always_comb begin
        issue = 1'b0;
        value = h1;
        unique case (pm)
            MODE_LAST:   begin issue = sel && (nobs != '0);               value = h1;           end
            MODE_STRIDE: begin issue = sel && two_obs;                    value = stride_guess; end
            MODE_ADAPT:  begin issue = sel && two_obs && (conf >= thr);  value = stride_guess; end
            MODE_OFF:    begin issue = 1'b0;                              value = h1;           end
        endcase
    end

endmodule

// File: rtl/lvp_stats.sv
module lvp_stats #(
    parameter int CNT_W = 16,
    parameter int NUM   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM-1:0]   inc,
    output logic [CNT_W-1:0] cnt [NUM]
);

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)         cnt[g] <= '0;
            else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
        end
    end

endmodule

// File: rtl/miss_value_predictor.sv
module miss_value_predictor
    import lvp_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int PC_W      = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [PC_W-1:0]   cfg_pc,
    input  logic              cfg_clear,
    input  logic              thr_we,
    input  logic [2:0]        thr_val,
    input  logic              lk_miss,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              pred_valid,
    output logic [DATA_W-1:0] pred_value,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [DATA_W-1:0] upd_value,
    output logic [CNT_W-1:0]  cnt_issued,
    output logic [CNT_W-1:0]  cnt_correct,
    output logic [CNT_W-1:0]  cnt_skipped
);

    localparam int N_STATS = 3;

    meta_t             meta_a [N_ENTRIES];
    logic [PC_W-1:0]   tag_a  [N_ENTRIES];
    logic [DATA_W-1:0] h1_a   [N_ENTRIES];
    logic [DATA_W-1:0] h2_a   [N_ENTRIES];
    logic [N_ENTRIES-1:0] live_v;

    logic [CONF_W-1:0] thr_q;
    logic              lk_hit, up_hit;
    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic              lk_sel, up_sel;
    logic              lk_issue, up_issue;
    logic [DATA_W-1:0] lk_value, up_value;
    logic [CONF_W-1:0] lk_conf;
    logic              skip_now, correct_now;
    logic [CNT_W-1:0]  stat_cnt [N_STATS];

    always_ff @(posedge clk) begin
        if (rst)         thr_q <= THR_RESET;
        else if (thr_we) thr_q <= thr_val;
    end

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        assign live_v[g] = meta_a[g].live;
        lvp_entry #(.PC_W(PC_W), .DATA_W(DATA_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .clear     (cfg_clear),
            .cfg_sel   (cfg_we && cfg_idx == IDX_W'(g)),
            .cfg_pc    (cfg_pc),
            .upd_sel   (up_sel && up_idx == IDX_W'(g)),
            .upd_value (upd_value),
            .meta      (meta_a[g]),
            .tag       (tag_a[g]),
            .h1        (h1_a[g]),
            .h2        (h2_a[g])
        );
    end

    lvp_match #(.N(N_ENTRIES), .PC_W(PC_W)) u_lk_match (
        .live (live_v), .tags (tag_a), .key (lk_pc), .hit (lk_hit), .idx (lk_idx)
    );

    lvp_match #(.N(N_ENTRIES), .PC_W(PC_W)) u_up_match (
        .live (live_v), .tags (tag_a), .key (upd_pc), .hit (up_hit), .idx (up_idx)
    );

    assign lk_sel  = lk_miss && lk_hit;
    assign up_sel  = upd_valid && up_hit;
    assign lk_conf = meta_a[lk_idx].conf;

    lvp_predict #(.DATA_W(DATA_W)) u_lk_pred (
        .mode  (mode_i),
        .sel   (lk_sel),
        .nobs  (meta_a[lk_idx].nobs),
        .conf  (lk_conf),
        .thr   (thr_q),
        .h1    (h1_a[lk_idx]),
        .h2    (h2_a[lk_idx]),
        .issue (lk_issue),
        .value (lk_value)
    );

    // Same predictor evaluated on the pre-training state of the updated entry
    lvp_predict #(.DATA_W(DATA_W)) u_up_pred (
        .mode  (mode_i),
        .sel   (up_sel),
        .nobs  (meta_a[up_idx].nobs),
        .conf  (meta_a[up_idx].conf),
        .thr   (thr_q),
        .h1    (h1_a[up_idx]),
        .h2    (h2_a[up_idx]),
        .issue (up_issue),
        .value (up_value)
    );

    assign pred_valid  = lk_issue;
    assign pred_value  = lk_value;
    assign skip_now    = lk_sel && (pmode_e'(mode_i) == MODE_ADAPT) && !lk_issue;
    assign correct_now = up_issue && (up_value == upd_value);

    lvp_stats #(.CNT_W(CNT_W), .NUM(N_STATS)) u_stats (
        .clk (clk),
        .rst (rst),
        .inc ({skip_now, correct_now, lk_issue}),
        .cnt (stat_cnt)
    );

    assign cnt_issued  = stat_cnt[0];
    assign cnt_correct = stat_cnt[1];
    assign cnt_skipped = stat_cnt[2];

    assert_pred_needs_miss_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_miss |-> !pred_valid);

    assert_adapt_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd2 && pred_valid) |-> (lk_conf >= thr_q));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_clear |=> !pred_valid);

    assert_issue_counted_R9: assert property (@(posedge clk) disable iff (rst)
        pred_valid |=> (cnt_issued == $past(cnt_issued) + 1'b1));

    assert_issue_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !pred_valid |=> $stable(cnt_issued));

endmodule

// File: tb/tb_miss_value_predictor.sv
`timescale 1ns/1ps
module tb_miss_value_predictor;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic        cfg_we, cfg_clear, thr_we, lk_miss, upd_valid;
    logic [2:0]  cfg_idx;
    logic [2:0]  thr_val;
    logic [31:0] cfg_pc, lk_pc, upd_pc, upd_value;
    logic        pred_valid;
    logic [31:0] pred_value;
    logic [15:0] cnt_issued, cnt_correct, cnt_skipped;

    always #10 clk = ~clk;

    miss_value_predictor dut (
        .clk(clk), .rst(rst), .mode_i(mode),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pc(cfg_pc), .cfg_clear(cfg_clear),
        .thr_we(thr_we), .thr_val(thr_val),
        .lk_miss(lk_miss), .lk_pc(lk_pc),
        .pred_valid(pred_valid), .pred_value(pred_value),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_value(upd_value),
        .cnt_issued(cnt_issued), .cnt_correct(cnt_correct), .cnt_skipped(cnt_skipped)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    bit          m_cfg  [N];
    logic [31:0] m_pc   [N];
    logic [31:0] m_h1   [N];
    logic [31:0] m_h2   [N];
    int          m_nobs [N];
    int          m_conf [N];
    int          m_thr;
    int          m_iss, m_cor, m_skp;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int find(input logic [31:0] pc);
        for (int i = 0; i < N; i++)
            if (m_cfg[i] && m_pc[i] == pc) return i;
        return -1;
    endfunction

    task automatic model_pred(input int i, output bit ok, output logic [31:0] val);
        logic [31:0] s;
        s  = m_h1[i] + m_h1[i] - m_h2[i];
        ok = 1'b0;
        val = m_h1[i];
        case (mode)
            2'd0: begin ok = (m_nobs[i] >= 1); val = m_h1[i]; end
            2'd1: begin ok = (m_nobs[i] >= 2); val = s; end
            2'd2: begin ok = (m_nobs[i] >= 2) && (m_conf[i] >= m_thr); val = s; end
            default: ok = 1'b0;
        endcase
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_cfg[i] = 0; m_pc[i] = '0; m_h1[i] = '0; m_h2[i] = '0;
            m_nobs[i] = 0; m_conf[i] = 0;
        end
    endtask

    task automatic compare_all();
        int          i;
        bit          ev;
        logic [31:0] evv;
        string       req;
        i  = find(lk_pc);
        ev = 0; evv = '0;
        if (lk_miss && i >= 0) model_pred(i, ev, evv);
        if (!lk_miss)       req = "R1";
        else if (i < 0)     req = "R2";
        else if (mode == 0) req = "R3";
        else if (mode == 1) req = "R4";
        else if (mode == 2) req = "R6";
        else                req = "R1";
        chk(pred_valid === ev, req, "pred_valid", pred_valid, ev);
        if (ev && pred_valid === 1'b1)
            chk(pred_value === evv, req, "pred_value", pred_value, evv);
        chk(cnt_issued  === 16'(m_iss), "R9",  "cnt_issued",  cnt_issued,  16'(m_iss));
        chk(cnt_correct === 16'(m_cor), "R10", "cnt_correct", cnt_correct, 16'(m_cor));
        chk(cnt_skipped === 16'(m_skp), "R11", "cnt_skipped", cnt_skipped, 16'(m_skp));
    endtask

    task automatic model_step();
        int          i;
        bit          ok;
        logic [31:0] v;
        if (lk_miss) begin
            i = find(lk_pc);
            if (i >= 0) begin
                model_pred(i, ok, v);
                if (ok) m_iss++;
                else if (mode == 2) m_skp++;
            end
        end
        if (upd_valid) begin
            i = find(upd_pc);
            if (i >= 0) begin
                model_pred(i, ok, v);
                if (ok && v == upd_value) m_cor++;
                if (m_nobs[i] >= 2) begin
                    if (upd_value == m_h1[i] + m_h1[i] - m_h2[i])
                        m_conf[i] = (m_conf[i] < 7) ? m_conf[i] + 1 : 7;
                    else
                        m_conf[i] = (m_conf[i] > 0) ? m_conf[i] - 1 : 0;
                end
                m_h2[i] = m_h1[i];
                m_h1[i] = upd_value;
                if (m_nobs[i] < 3) m_nobs[i]++;
            end
        end
        if (cfg_we) begin
            m_cfg[cfg_idx] = 1; m_pc[cfg_idx] = cfg_pc;
            m_h1[cfg_idx] = '0; m_h2[cfg_idx] = '0;
            m_nobs[cfg_idx] = 0; m_conf[cfg_idx] = 0;
        end
        if (thr_we) m_thr = thr_val;
        if (cfg_clear) model_reset();
    endtask

    task automatic idle();
        cfg_we = 0; cfg_clear = 0; thr_we = 0; lk_miss = 0; upd_valid = 0;
    endtask

    task automatic step();
        #2;
        compare_all();
        model_step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_cfg(input int idx, input logic [31:0] pc);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_pc = pc; step();
    endtask

    task automatic do_thr(input int t);
        thr_we = 1; thr_val = 3'(t); step();
    endtask

    task automatic do_upd(input logic [31:0] pc, input logic [31:0] val);
        upd_valid = 1; upd_pc = pc; upd_value = val; step();
    endtask

    task automatic do_look(input logic [31:0] pc, input string req,
                           input bit v, input logic [31:0] val);
        lk_miss = 1; lk_pc = pc;
        #1;
        chk(pred_valid === v, req, "directed pred_valid", pred_valid, v);
        if (v) chk(pred_value === val, req, "directed pred_value", pred_value, val);
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1; mode = 2'd0; idle();
        cfg_idx = '0; cfg_pc = '0; thr_val = '0; lk_pc = '0; upd_pc = '0; upd_value = '0;
        model_reset(); m_thr = 4; m_iss = 0; m_cor = 0; m_skp = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // reset state of the counters (R9, R10, R11)
        chk(cnt_issued  === '0, "R9",  "reset cnt_issued",  cnt_issued,  0);
        chk(cnt_correct === '0, "R10", "reset cnt_correct", cnt_correct, 0);
        chk(cnt_skipped === '0, "R11", "reset cnt_skipped", cnt_skipped, 0);
        @(negedge clk);

        do_look(32'h100, "R2", 0, '0);
        do_cfg(0, 32'h100); do_cfg(1, 32'h200); do_cfg(2, 32'h300);
        do_cfg(3, 32'h100); do_cfg(4, 32'h400); do_cfg(5, 32'h500); do_cfg(6, 32'h600);

        // R3 last value
        mode = 2'd0;
        do_look(32'h100, "R3", 0, '0);
        do_upd(32'h100, 32'd5);
        do_look(32'h100, "R3", 1, 32'd5);
        // R7 same-cycle lookup sees pre-update state
        lk_miss = 1; lk_pc = 32'h100; upd_valid = 1; upd_pc = 32'h100; upd_value = 32'd9;
        #1;
        chk(pred_valid === 1'b1 && pred_value === 32'd5, "R7", "same-cycle lookup",
            pred_value, 32'd5);
        step();
        do_look(32'h100, "R7", 1, 32'd9);

        // R4 stride
        mode = 2'd1;
        do_upd(32'h200, 32'd10);
        do_look(32'h200, "R4", 0, '0);
        do_upd(32'h200, 32'd20); do_upd(32'h200, 32'd30);
        do_look(32'h200, "R4", 1, 32'd40);
        do_upd(32'h200, 32'd40);
        lk_miss = 0; lk_pc = 32'h200; #1;
        chk(pred_valid === 1'b0, "R1", "no miss no prediction", pred_valid, 0);
        step();
        do_upd(32'h300, 32'hFFFF_FFF0); do_upd(32'h300, 32'hFFFF_FFF8);
        do_look(32'h300, "R4", 1, 32'h0000_0000);
        // R7 unconfigured update ignored
        do_upd(32'h999, 32'd1);
        do_look(32'h999, "R7", 0, '0);
        do_look(32'h200, "R7", 1, 32'd50);

        // R6 adaptive gate
        mode = 2'd2;
        do_upd(32'h400, 32'd3); do_upd(32'h400, 32'd6); do_upd(32'h400, 32'd9);
        do_upd(32'h400, 32'd12); do_upd(32'h400, 32'd15);
        do_look(32'h400, "R6", 0, '0);
        do_upd(32'h400, 32'd18);
        do_look(32'h400, "R6", 1, 32'd21);
        do_upd(32'h400, 32'd0);
        do_look(32'h400, "R6", 0, '0);
        do_thr(2);
        do_look(32'h400, "R6", 1, 32'hFFFF_FFEE);

        // R5 upper saturation
        do_thr(7);
        for (int k = 1; k <= 12; k++) do_upd(32'h500, 32'(k));
        do_look(32'h500, "R5", 1, 32'd13);
        do_upd(32'h500, 32'd100);
        do_look(32'h500, "R5", 0, '0);
        do_upd(32'h500, 32'd188);
        do_look(32'h500, "R5", 1, 32'd276);
        // R5 lower saturation
        do_thr(2);
        do_upd(32'h600, 32'd0); do_upd(32'h600, 32'd0);
        do_upd(32'h600, 32'd5); do_upd(32'h600, 32'd1);
        do_upd(32'h600, 32'hFFFF_FFFD);
        do_look(32'h600, "R5", 0, '0);

        // R12 duplicate PCs
        mode = 2'd0;
        do_cfg(0, 32'h700);
        do_look(32'h100, "R12", 0, '0);
        do_upd(32'h100, 32'd77);
        do_look(32'h100, "R12", 1, 32'd77);

        // R1 mode off
        mode = 2'd3;
        do_look(32'h200, "R1", 0, '0);

        // R8 clear
        mode = 2'd1;
        cfg_clear = 1; step();
        do_look(32'h200, "R8", 0, '0);

        // randomised phase against the model
        for (int k = 0; k < 8; k++) do_cfg(k, 32'h1000 + 32'(k % 6) * 4);
        for (int c = 0; c < 3000; c++) begin
            if ($urandom % 50 == 0) mode = 2'($urandom % 4);
            if ($urandom % 80 == 0) begin thr_we = 1; thr_val = 3'($urandom); end
            lk_miss   = ($urandom % 2) == 0;
            lk_pc     = 32'h1000 + 32'($urandom % 7) * 4;
            upd_valid = ($urandom % 2) == 0;
            upd_pc    = 32'h1000 + 32'($urandom % 7) * 4;
            upd_value = ($urandom % 5 == 0) ? 32'($urandom) : 32'(c) * 32'd3;
            if ($urandom % 400 == 0) begin cfg_we = 1; cfg_idx = 3'($urandom); cfg_pc = 32'h1000 + 32'($urandom % 7) * 4; end
            step();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule